// File: doc/BRIEF.md
# Real-Time Clock Core with Phased Prescaler Restart

This core keeps calendar time (seconds, minutes, hours, day of month, month, two-digit year) in a small register file. A host reaches the registers through a one-cycle address/data port. Addresses 0 to 5 hold the time fields in that order. Address 6 is the rate-select register, address 7 is control, and address 8 holds the interrupt flags. Reads are registered: data and a valid strobe appear one clock after the request. An input `tick` comes from a prescaled oscillator. Every `TICKS_PER_SEC` ticks the prescaler asks for a one-second advance, and that advance carries through the whole date.

Software sets the time with a fixed sequence:

1. Raise the SET bit.
2. Hold the divider in reset.
3. Write the fields.
4. Drop SET.
5. Release the divider.

With this order, the first new second begins exactly half a second after the release. A status bit in the rate-select register rises a fixed number of ticks before each update and falls on the edge at which the new second appears. Software can use that falling edge to find the start of a second.

The low four bits of the rate-select register set the period of a periodic event. Three flags record periodic, alarm and update events. Each flag can raise an active-high interrupt when its own enable bit is set, and reading the flag register clears all of them. Divider codes other than run (010) and reset (11x) stop the prescaler but do not clear it.

Top module: `rtc_core`

## Requirements
- R1: After reset the fields read as follows: seconds, minutes and hours 0; day and month 1; year 0. Rate-select reads 0x60 (divider held), control reads 0x00, flags read 0x00, and irq is low.
- R2: While control bit 2 is 0, every time field is written and read as packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R3: While control bit 2 is 1, every time field is written and read as a plain binary number.
- R4: Each update adds one second, with carry through the following fields:
  - minutes (0 to 59) and hours (0 to 23);
  - day, up to the month length: 30 for April, June, September and November; 29 for February when the year is divisible by 4, otherwise 28; 31 for all other months;
  - month (1 to 12);
  - year (0 to 99, wrapping to 0).
- R5: While control bit 7 (SET) is 1, no update happens and the UIP bit reads 0.
- R6: Rate-select bits 6:4 control the divider. Code 010 runs it. Codes 110 and 111 hold the prescaler cleared, and no update or periodic event occurs while it is held. Writing 010 while the divider is held and SET is 0 makes the first update happen exactly TICKS_PER_SEC/2 ticks later.
- R7: If the divider is released while SET is still 1, the prescaler starts from zero. The first update then comes a full TICKS_PER_SEC ticks after the release.
- R8: Rate-select bit 7 (UIP) rises UIP_LEAD ticks before each update. It falls on the same clock edge at which the time fields take their new values.
- R9: When rate-select bits 3:0 hold a nonzero value r, a periodic event occurs every 2^(r-1) ticks while the divider runs and sets flag bit 6. When r is 0 there is no periodic event.
- R10: The flag register (address 8) has the following bits:
  - bit 6: periodic flag;
  - bit 5: alarm flag, always 0;
  - bit 4: update flag, set by every update;
  - bit 7: summary, equal to any pending flag whose enable is set (control bit 6 for periodic, bit 5 for alarm, bit 4 for update).

  The irq output equals bit 7. A read returns the flags and clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled oscillator tick, one clock wide per tick |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one clock after host_rd |
| irq | output | 1 | Active-high interrupt, summary of enabled pending flags |

## Verification
Faults in the prescaler show up as a time field that changes one or more ticks away from its expected slot after a release. Faults in the status bit show up as a wrong bit 7 in a rate-select read that lands a few ticks before a rollover. A bad carry chain stays hidden until a read right after a wrap: the fields that should have reset to their minimum show stale or overflowed values within one clock of the update. A flag that fails to clear is seen on the very next flag read and as irq staying high.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [4:0] day;
    logic [3:0] mon;
    logic [6:0] year;
  } rtc_time_t;

  localparam logic [2:0] DIV_RUN = 3'b010;

  localparam logic [3:0] ADDR_RATE  = 4'd6;
  localparam logic [3:0] ADDR_CTRL  = 4'd7;
  localparam logic [3:0] ADDR_FLAGS = 4'd8;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return 7'(7'(b[7:4]) * 7'd10 + 7'(b[3:0]));
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] year);
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction

  function automatic rtc_time_t advance(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec < 6'd59) n.sec = t.sec + 6'd1;
    else begin
      n.sec = '0;
      if (t.min < 6'd59) n.min = t.min + 6'd1;
      else begin
        n.min = '0;
        if (t.hour < 5'd23) n.hour = t.hour + 5'd1;
        else begin
          n.hour = '0;
          if (t.day < month_len(t.mon, t.year)) n.day = t.day + 5'd1;
          else begin
            n.day = 5'd1;
            if (t.mon < 4'd12) n.mon = t.mon + 4'd1;
            else begin
              n.mon  = 4'd1;
              n.year = (t.year < 7'd99) ? t.year + 7'd1 : 7'd0;
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int TICKS_PER_SEC = 64,
  parameter int UIP_LEAD      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] div_code,
  input  logic [3:0] rate,
  input  logic       set_mode,
  input  logic       div_wr,
  input  logic [2:0] new_div,
  output logic       upd_evt,
  output logic       pf_evt,
  output logic       uip,
  output logic       div_held
);
  import rtc_pkg::*;

  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST    = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF    = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] UIP_PRE = CW'(TICKS_PER_SEC - UIP_LEAD - 1);

  logic [CW-1:0] cnt;
  logic          running, release_evt, pf_ok;
  logic [CW-1:0] pmask;

  function automatic logic [CW-1:0] rate_mask(input logic [3:0] r);
    logic [CW-1:0] m;
    for (int i = 0; i < CW; i++) m[i] = (i < int'(r) - 1);
    return m;
  endfunction

  assign div_held    = (div_code[2:1] == 2'b11);
  assign running     = (div_code == DIV_RUN);
  assign release_evt = div_wr && div_held && (new_div == DIV_RUN);
  assign pmask       = rate_mask(rate);
  assign pf_ok       = (rate != 4'd0) && (int'(rate) - 1 <= CW);

  assign upd_evt = running && tick && (cnt == LAST) && !set_mode;
  assign pf_evt  = running && tick && pf_ok && ((cnt & pmask) == pmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (release_evt)      cnt <= set_mode ? '0 : HALF;
    else if (div_held)         cnt <= '0;
    else if (running && tick)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     uip <= 1'b0;
    else if (set_mode || !running)  uip <= 1'b0;
    else if (upd_evt)               uip <= 1'b0;
    else if (tick && cnt == UIP_PRE) uip <= 1'b1;
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_evt,
  input  logic               field_wr,
  input  logic [2:0]         field_sel,
  input  logic [6:0]         field_val,
  output rtc_pkg::rtc_time_t cur
);
  import rtc_pkg::*;

  localparam rtc_time_t RESET_TIME = '{sec: 6'd0, min: 6'd0, hour: 5'd0,
                                       day: 5'd1, mon: 4'd1, year: 7'd0};

  rtc_time_t nxt;

  always_comb begin
    nxt = upd_evt ? advance(cur) : cur;
    if (field_wr) begin
      case (field_sel)
        3'd0:    nxt.sec  = field_val[5:0];
        3'd1:    nxt.min  = field_val[5:0];
        3'd2:    nxt.hour = field_val[4:0];
        3'd3:    nxt.day  = field_val[4:0];
        3'd4:    nxt.mon  = field_val[3:0];
        default: nxt.year = field_val;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= RESET_TIME;
    else        cur <= nxt;
  end

endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pf_set,
  input  logic       uf_set,
  input  logic       rd_clr,
  input  logic [2:0] enables,
  output logic [2:0] flags,
  output logic       irq
);
  logic [2:0] set_vec;

  assign set_vec = {pf_set, 1'b0, uf_set};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags <= '0;
    else if (rd_clr) flags <= set_vec;
    else             flags <= flags | set_vec;
  end

  assign irq = |(flags & enables);

endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int TICKS_PER_SEC = 64,
  parameter int UIP_LEAD      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_rvalid,
  output logic       irq
);
  import rtc_pkg::*;

  logic [2:0] div_q;
  logic [3:0] rate_q;
  logic       set_q, pie_q, aie_q, uie_q, bin_q;
  logic       upd_evt, pf_evt, uip, div_held;
  logic       field_wr, rate_wr, ctrl_wr, flag_rd;
  logic [6:0] field_val;
  logic [2:0] flags;
  rtc_time_t  cur;
  logic [7:0] rd_mux;
  logic       unused_wbits;

  assign field_wr  = host_wr && (host_addr < 4'd6);
  assign rate_wr   = host_wr && (host_addr == ADDR_RATE);
  assign ctrl_wr   = host_wr && (host_addr == ADDR_CTRL);
  assign flag_rd   = host_rd && (host_addr == ADDR_FLAGS);
  assign field_val = bin_q ? host_wdata[6:0] : from_bcd(host_wdata);
  assign unused_wbits = ^{host_wdata[3], host_wdata[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 3'b110;
      rate_q <= 4'd0;
    end else if (rate_wr) begin
      div_q  <= host_wdata[6:4];
      rate_q <= host_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {set_q, pie_q, aie_q, uie_q, bin_q} <= '0;
    else if (ctrl_wr) begin
      set_q <= host_wdata[7];
      pie_q <= host_wdata[6];
      aie_q <= host_wdata[5];
      uie_q <= host_wdata[4];
      bin_q <= host_wdata[2];
    end
  end

  rtc_divider #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_LEAD(UIP_LEAD)) div_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .div_code(div_q), .rate(rate_q),
    .set_mode(set_q), .div_wr(rate_wr), .new_div(host_wdata[6:4]),
    .upd_evt(upd_evt), .pf_evt(pf_evt), .uip(uip), .div_held(div_held)
  );

  rtc_calendar cal_i (
    .clk(clk), .rst_n(rst_n), .upd_evt(upd_evt), .field_wr(field_wr),
    .field_sel(host_addr[2:0]), .field_val(field_val), .cur(cur)
  );

  rtc_flags flg_i (
    .clk(clk), .rst_n(rst_n), .pf_set(pf_evt), .uf_set(upd_evt), .rd_clr(flag_rd),
    .enables({pie_q, aie_q, uie_q}), .flags(flags), .irq(irq)
  );

  function automatic logic [7:0] show(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

  always_comb begin
    case (host_addr)
      4'd0:       rd_mux = show(7'(cur.sec), bin_q);
      4'd1:       rd_mux = show(7'(cur.min), bin_q);
      4'd2:       rd_mux = show(7'(cur.hour), bin_q);
      4'd3:       rd_mux = show(7'(cur.day), bin_q);
      4'd4:       rd_mux = show(7'(cur.mon), bin_q);
      4'd5:       rd_mux = show(cur.year, bin_q);
      ADDR_RATE:  rd_mux = {uip, div_q, rate_q};
      ADDR_CTRL:  rd_mux = {set_q, pie_q, aie_q, uie_q, 1'b0, bin_q, 2'b00};
      ADDR_FLAGS: rd_mux = {irq, flags[2], flags[1], flags[0], 4'b0000};
      default:    rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_evt,
  input logic       pf_evt,
  input logic       uip,
  input logic       set_mode,
  input logic       div_held,
  input logic       rd_clr,
  input logic       field_wr,
  input logic [2:0] flags,
  input logic       irq,
  input logic [5:0] sec
);

  AST_SET_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    set_mode |-> !upd_evt);  // R5

  AST_UIP_QUIET_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && $past(set_mode)) |-> !uip);  // R5

  AST_HELD_DIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    div_held |-> (!upd_evt && !pf_evt));  // R6

  AST_UIP_DROPS_AT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> !uip);  // R8

  AST_SEC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !field_wr && sec == 6'd59) |=> (sec == 6'd0));  // R4

  AST_READ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !pf_evt && !upd_evt) |=> (flags == 3'b000));  // R10

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 3'b000));  // R10

endmodule

bind rtc_core rtc_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .upd_evt(upd_evt), .pf_evt(pf_evt), .uip(uip),
  .set_mode(set_q), .div_held(div_held), .rd_clr(flag_rd), .field_wr(field_wr),
  .flags(flags), .irq(irq), .sec(cur.sec)
);

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;
  localparam int TPS  = 64;
  localparam int LEAD = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, tick, host_wr, host_rd;
  logic [3:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       host_rvalid, irq;

  rtc_core #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .irq(irq)
  );

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  int n_vec = 0, n_bad = 0;
  int edge_cnt = 0;
  bit done = 0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (host_rvalid) begin
      n_vec++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 stray read data %02h expected none", host_rdata);
      end else begin
        item_t it;
        it = q.pop_front();
        if (host_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: read %02h expected %02h", it.tag, host_rdata, it.exp);
        end
      end
    end
  end

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic at_edge(input int t);
    while (edge_cnt < t - 1) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    host_rd = 1'b1; host_addr = a;
    q.push_back('{e, tag});
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic rd_at(input int t, input logic [3:0] a, input logic [7:0] e, input string tag);
    at_edge(t);
    rd(a, e, tag);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq %0b expected %0b", tag, act, exp);
    end
  endtask

  // set fields under SET with divider held; returns the release edge
  task automatic load_time(input logic bin, input int s, input int mi, input int h,
                           input int d, input int mo, input int y, output int rel);
    wr(4'd7, bin ? 8'h84 : 8'h80);
    wr(4'd6, 8'h66);
    wr(4'd0, bin ? 8'(s)  : bcd(s));
    wr(4'd1, bin ? 8'(mi) : bcd(mi));
    wr(4'd2, bin ? 8'(h)  : bcd(h));
    wr(4'd3, bin ? 8'(d)  : bcd(d));
    wr(4'd4, bin ? 8'(mo) : bcd(mo));
    wr(4'd5, bin ? 8'(y)  : bcd(y));
    wr(4'd7, bin ? 8'h04 : 8'h00);
    rel = edge_cnt + 1;
    wr(4'd6, 8'h26);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_vec++; n_bad++;
    $display("FAIL R1 watchdog expired: done %0b expected 1", done);
    finish_run();
  end

  initial begin
    int e0, e3, e4, e5, e6, e7;
    rst_n = 1'b0; tick = 1'b1; host_wr = 1'b0; host_rd = 1'b0;
    host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq, 1'b0, "R1 irq");
    rd(4'd0, 8'h00, "R1 sec");
    rd(4'd3, 8'h01, "R1 day");
    rd(4'd4, 8'h01, "R1 month");
    rd(4'd6, 8'h60, "R1 rate-select");
    rd(4'd7, 8'h00, "R1 control");
    rd(4'd8, 8'h00, "R1 flags");

    // R2 R4 R6 R8: BCD year-end rollover after a half-second release
    load_time(1'b0, 59, 59, 23, 31, 12, 99, e0);
    rd(4'd0, 8'h59, "R2 bcd sec readback");
    rd_at(e0 + 27, 4'd6, 8'h26, "R8 uip not early");
    rd_at(e0 + 29, 4'd6, 8'hA6, "R8 uip high before update");
    rd_at(e0 + 32, 4'd0, 8'h59, "R6 no update before half second");
    rd(4'd0, 8'h00, "R6 sec wraps at half second");
    rd(4'd1, 8'h00, "R4 min wrap");
    rd(4'd2, 8'h00, "R4 hour wrap");
    rd(4'd3, 8'h01, "R4 day wrap");
    rd(4'd4, 8'h01, "R4 month wrap");
    rd(4'd5, 8'h00, "R4 year wrap");
    rd(4'd6, 8'h26, "R8 uip low after update");
    rd(4'd8, 8'h50, "R10 flags pf+uf");
    rd(4'd8, 8'h00, "R10 flags cleared by read");
    chk(irq, 1'b0, "R10 no irq while disabled");

    // R10 periodic interrupt enabled
    wr(4'd7, 8'h40);
    at_edge(e0 + 65);
    chk(irq, 1'b1, "R10 irq on enabled pf");
    rd(4'd8, 8'hC0, "R10 flags with summary");
    chk(irq, 1'b0, "R10 irq drops after read");

    // R9 rate 3: event every 4 ticks
    wr(4'd6, 8'h63);
    e3 = edge_cnt + 1;
    wr(4'd6, 8'h23);
    rd_at(e3 + 5, 4'd8, 8'hC0, "R9 first event");
    rd(4'd8, 8'h00, "R9 no event yet");
    rd(4'd8, 8'h00, "R9 still none");
    rd_at(e3 + 9, 4'd8, 8'hC0, "R9 second event after four ticks");

    // R9 rate 0: no periodic event
    wr(4'd7, 8'h00);
    wr(4'd6, 8'h60);
    e4 = edge_cnt + 1;
    wr(4'd6, 8'h20);
    rd_at(e4 + 40, 4'd8, 8'h10, "R9 rate zero gives only update flag");
    chk(irq, 1'b0, "R10 update flag without enable");

    // R3 R4 binary leap February
    load_time(1'b1, 59, 59, 23, 28, 2, 24, e5);
    rd(4'd0, 8'd59, "R3 binary sec readback");
    rd_at(e5 + 33, 4'd3, 8'd29, "R4 leap day 29");
    rd(4'd4, 8'd2, "R4 still February");
    rd(4'd5, 8'd24, "R3 binary year");

    // R4 non-leap February
    load_time(1'b1, 59, 59, 23, 28, 2, 23, e6);
    rd_at(e6 + 33, 4'd3, 8'd1, "R4 non-leap day wraps");
    rd(4'd4, 8'd3, "R4 March");

    // R5 SET freezes time
    wr(4'd7, 8'h84);
    rd_at(e6 + 100, 4'd0, 8'd0, "R5 no update under SET");
    rd(4'd6, 8'h26, "R5 uip low under SET");

    // R7 release before clearing SET
    wr(4'd6, 8'h66);
    e7 = edge_cnt + 1;
    wr(4'd6, 8'h26);
    wr(4'd7, 8'h04);
    rd_at(e7 + 34, 4'd0, 8'd0, "R7 no half-second update");
    rd_at(e7 + 64, 4'd0, 8'd0, "R7 not before full second");
    rd(4'd0, 8'd1, "R7 update after full second");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R10 reads outstanding %0d expected 0", q.size());
    end
    finish_run();
  end

endmodule